// File: doc/BRIEF.md
# Data-Space Address Generation Unit

This block sits in the operand path of an 8-bit microcontroller core. For each memory-access request it forms one 16-bit data-space address and decodes it into one of three targets. The three targets are the register-file window at the bottom of data space, the I/O window just above it, and general SRAM.

The block handles three kinds of addressing:
- a full 16-bit direct address;
- a 6-bit I/O-space address, which is moved up by a fixed offset;
- indirect addressing through one of three 16-bit pointer pairs, used plainly, with post-increment, or with a small unsigned displacement.

The block also checks the single-bit I/O operations, which may only reach the lower half of the I/O window. For each request it returns the effective address, a one-hot target select, the index of the slot inside that target, the new pointer value and a one-cycle write-back strobe.

The outputs are registered. A request presented with `req_valid` in one cycle produces its result after the next rising edge. The outputs then hold until the next request, except `ptr_wb` and `out_valid`, which drop to zero.

Top module: `dspace_agu`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, every output is zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high, and low after any cycle without a request. `ptr_wb` is never high while `out_valid` is low.
- R3: In direct mode (`mode` = 0), `eff_addr` equals `imm_addr` across the whole range 0x0000 to 0xFFFF.
- R4: In I/O mode (`mode` = 1), `eff_addr` equals `io_addr` + 0x20. For example, I/O address 0x18 gives 0x38, and 0x3F gives 0x5F.
- R5: An effective address below 0x0020 selects the register file (`tgt_sel` = 3'b001), and `local_idx` equals the address.
- R6: An effective address from 0x0020 to 0x005F selects the I/O window (`tgt_sel` = 3'b010), and `local_idx` equals the address minus 0x20.
- R7: An effective address of 0x0060 or above selects SRAM (`tgt_sel` = 3'b100), and `local_idx` equals the address minus 0x60. Extended registers at 0x0060 and above are therefore reached only through data-space addresses.
- R8: In the pointer modes (`mode` 2, 3 and 4), `ptr_sel` 0, 1 and 2 pick pointers X, Y and Z. `ptr_reg_idx` reports the low-byte register of the pair: 26, 28 or 30. The high byte is held in the next register up. In all other modes, and on an illegal request, `ptr_reg_idx` is 0.
- R9: In post-increment mode (`mode` = 3), `eff_addr` equals `ptr_val`, `ptr_next` equals `ptr_val` + 1 with the carry running through all 16 bits (0x01FF gives 0x0200, and 0xFFFF gives 0x0000), and `ptr_wb` is high for that single result cycle.
- R10: In displacement mode (`mode` = 4), `eff_addr` equals `ptr_val` + `disp` modulo 2^16, where `disp` is unsigned 0 to 63. `ptr_next` equals `ptr_val` and `ptr_wb` stays low.
- R11: In plain indirect mode (`mode` = 2), `eff_addr` equals `ptr_val`. Outside post-increment, `ptr_next` equals `ptr_val` and `ptr_wb` stays low.
- R12: The request is illegal in any of these cases: a single-bit operation (`bit_op` = 1) in I/O mode with `io_addr` of 32 or more; `ptr_sel` = 3 in a pointer mode; or `mode` 5 to 7. An illegal request sets `illegal`, drives `eff_addr`, `tgt_sel`, `local_idx` and `ptr_wb` to zero, and returns `ptr_next` = `ptr_val`. In every mode other than I/O, `bit_op` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| mode | input | 3 | 0 direct, 1 I/O, 2 indirect, 3 post-increment, 4 displacement |
| bit_op | input | 1 | Request is a single-bit I/O set, clear or test |
| imm_addr | input | 16 | Direct data-space address |
| io_addr | input | 6 | I/O-space address |
| ptr_sel | input | 2 | 0 X, 1 Y, 2 Z |
| ptr_val | input | 16 | Current value of the selected pointer pair |
| disp | input | 6 | Unsigned displacement |
| out_valid | output | 1 | Result strobe |
| eff_addr | output | 16 | Effective data-space address |
| tgt_sel | output | 3 | One-hot target: bit 0 register file, bit 1 I/O, bit 2 SRAM |
| local_idx | output | 16 | Slot index inside the selected target |
| ptr_next | output | 16 | Pointer value to write back |
| ptr_wb | output | 1 | Pointer write-back strobe |
| ptr_reg_idx | output | 5 | Register number of the pointer's low byte |
| illegal | output | 1 | Request rejected |

## Verification
The only internal state in this block is the result register, so a wrong internal value cannot hide. It shows on the ports in the result cycle that directly follows the request. A wrong window boundary shows up as a wrong one-hot target or a shifted `local_idx` on the first address next to 0x20 or 0x60. A broken increment carry shows up as a wrong `ptr_next` on a pointer whose low byte is 0xFF. A write-back strobe that stays high too long, or fires in the wrong mode, is visible in the idle cycle after a result.

// File: rtl/dspace_agu.sv
module dspace_agu #(
  parameter int AW          = 16,
  parameter int IOW         = 6,
  parameter int QW          = 6,
  parameter int RF_SLOTS    = 32,
  parameter int IO_SLOTS    = 64,
  parameter int BIT_IO_SLOTS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [2:0]      mode,
  input  logic            bit_op,
  input  logic [AW-1:0]   imm_addr,
  input  logic [IOW-1:0]  io_addr,
  input  logic [1:0]      ptr_sel,
  input  logic [AW-1:0]   ptr_val,
  input  logic [QW-1:0]   disp,
  output logic            out_valid,
  output logic [AW-1:0]   eff_addr,
  output logic [2:0]      tgt_sel,
  output logic [AW-1:0]   local_idx,
  output logic [AW-1:0]   ptr_next,
  output logic            ptr_wb,
  output logic [4:0]      ptr_reg_idx,
  output logic            illegal
);
  localparam logic [AW-1:0] IO_BASE   = AW'(RF_SLOTS);
  localparam logic [AW-1:0] SRAM_BASE = AW'(RF_SLOTS + IO_SLOTS);
  localparam int            PTR_BASE  = RF_SLOTS - 6;

  localparam logic [2:0] M_DIRECT = 3'd0, M_IO = 3'd1, M_IND = 3'd2,
                         M_POST = 3'd3, M_DISP = 3'd4;
  localparam logic [2:0] T_RF = 3'b001, T_IO = 3'b010, T_MEM = 3'b100;

  logic            ptr_mode, bad;
  logic [AW-1:0]   addr_c, idx_c, next_c;
  logic [2:0]      tgt_c;
  logic [4:0]      pidx_c;

  assign ptr_mode = (mode == M_IND) || (mode == M_POST) || (mode == M_DISP);
  assign bad = (mode > M_DISP) || (ptr_mode && ptr_sel == 2'd3) ||
               (mode == M_IO && bit_op && 32'(io_addr) >= BIT_IO_SLOTS);

  always_comb begin
    case (mode)
      M_DIRECT: addr_c = imm_addr;
      M_IO:     addr_c = AW'(io_addr) + IO_BASE;
      M_DISP:   addr_c = ptr_val + AW'(disp);
      default:  addr_c = ptr_val;
    endcase
    if (bad) addr_c = '0;
  end

  always_comb begin
    if (bad) begin
      tgt_c = 3'b000;
      idx_c = '0;
    end else if (addr_c < IO_BASE) begin
      tgt_c = T_RF;
      idx_c = addr_c;
    end else if (addr_c < SRAM_BASE) begin
      tgt_c = T_IO;
      idx_c = addr_c - IO_BASE;
    end else begin
      tgt_c = T_MEM;
      idx_c = addr_c - SRAM_BASE;
    end
  end

  assign next_c = (!bad && mode == M_POST) ? ptr_val + AW'(1) : ptr_val;
  assign pidx_c = (!bad && ptr_mode) ? 5'(PTR_BASE + 2 * int'(ptr_sel)) : 5'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      eff_addr    <= '0;
      tgt_sel     <= '0;
      local_idx   <= '0;
      ptr_next    <= '0;
      ptr_wb      <= 1'b0;
      ptr_reg_idx <= '0;
      illegal     <= 1'b0;
    end else begin
      out_valid <= req_valid;
      ptr_wb    <= req_valid && !bad && mode == M_POST;
      if (req_valid) begin
        eff_addr    <= addr_c;
        tgt_sel     <= tgt_c;
        local_idx   <= idx_c;
        ptr_next    <= next_c;
        ptr_reg_idx <= pidx_c;
        illegal     <= bad;
      end
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> !out_valid); // R2
  AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb |-> out_valid); // R2
  AST_WB_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wb |-> ptr_next == eff_addr + AW'(1)); // R9
  AST_DISP_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && mode == M_DISP) |-> !ptr_wb && ptr_next == $past(ptr_val)); // R10
  AST_IO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && mode == M_IO) && !illegal) |-> eff_addr == AW'($past(io_addr)) + IO_BASE); // R4
  AST_RF_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_sel == T_RF |-> eff_addr < IO_BASE && local_idx == eff_addr); // R5
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> tgt_sel == 3'b000 && !ptr_wb); // R12
  AST_BITOP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && mode == M_IO && bit_op && 32'(io_addr) >= BIT_IO_SLOTS) |-> illegal); // R12
endmodule

// File: tb/dspace_agu_tb.sv
module dspace_agu_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, bit_op = 1'b0;
  logic [2:0] mode = '0;
  logic [15:0] imm_addr = '0, ptr_val = '0;
  logic [5:0] io_addr = '0, disp = '0;
  logic [1:0] ptr_sel = '0;
  logic out_valid, ptr_wb, illegal;
  logic [15:0] eff_addr, local_idx, ptr_next;
  logic [2:0] tgt_sel;
  logic [4:0] ptr_reg_idx;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dspace_agu dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode), .bit_op(bit_op),
    .imm_addr(imm_addr), .io_addr(io_addr), .ptr_sel(ptr_sel), .ptr_val(ptr_val),
    .disp(disp), .out_valid(out_valid), .eff_addr(eff_addr), .tgt_sel(tgt_sel),
    .local_idx(local_idx), .ptr_next(ptr_next), .ptr_wb(ptr_wb),
    .ptr_reg_idx(ptr_reg_idx), .illegal(illegal));

  typedef struct packed {
    logic [2:0]  m;
    logic        b;
    logic [1:0]  s;
    logic [15:0] imm;
    logic [5:0]  io;
    logic [15:0] p;
    logic [5:0]  q;
    logic [15:0] e_addr;
    logic [2:0]  e_tgt;
    logic [15:0] e_idx;
    logic [15:0] e_next;
    logic        e_wb;
    logic [4:0]  e_pidx;
    logic        e_ill;
  } vec_t;

  localparam int N = 24;
  localparam vec_t VECS [N] = '{
    '{3'd0,1'b0,2'd0,16'h0005,6'h00,16'h1234,6'd0, 16'h0005,3'b001,16'h0005,16'h1234,1'b0,5'd0,1'b0}, // R3 R5
    '{3'd0,1'b0,2'd0,16'h001F,6'h00,16'h1234,6'd0, 16'h001F,3'b001,16'h001F,16'h1234,1'b0,5'd0,1'b0}, // R5
    '{3'd0,1'b0,2'd0,16'h0020,6'h00,16'h1234,6'd0, 16'h0020,3'b010,16'h0000,16'h1234,1'b0,5'd0,1'b0}, // R6
    '{3'd0,1'b0,2'd0,16'h005F,6'h00,16'h1234,6'd0, 16'h005F,3'b010,16'h003F,16'h1234,1'b0,5'd0,1'b0}, // R6
    '{3'd0,1'b0,2'd0,16'h0060,6'h00,16'h1234,6'd0, 16'h0060,3'b100,16'h0000,16'h1234,1'b0,5'd0,1'b0}, // R7
    '{3'd0,1'b0,2'd0,16'h0062,6'h00,16'h1234,6'd0, 16'h0062,3'b100,16'h0002,16'h1234,1'b0,5'd0,1'b0}, // R7
    '{3'd0,1'b0,2'd0,16'hFFFF,6'h00,16'h1234,6'd0, 16'hFFFF,3'b100,16'hFF9F,16'h1234,1'b0,5'd0,1'b0}, // R3 R7
    '{3'd1,1'b0,2'd0,16'h0000,6'h18,16'h1234,6'd0, 16'h0038,3'b010,16'h0018,16'h1234,1'b0,5'd0,1'b0}, // R4
    '{3'd1,1'b0,2'd0,16'h0000,6'h3F,16'h1234,6'd0, 16'h005F,3'b010,16'h003F,16'h1234,1'b0,5'd0,1'b0}, // R4
    '{3'd1,1'b1,2'd0,16'h0000,6'h00,16'h1234,6'd0, 16'h0020,3'b010,16'h0000,16'h1234,1'b0,5'd0,1'b0}, // R4 R12
    '{3'd1,1'b1,2'd0,16'h0000,6'h1F,16'h1234,6'd0, 16'h003F,3'b010,16'h001F,16'h1234,1'b0,5'd0,1'b0}, // R12
    '{3'd1,1'b1,2'd0,16'h0000,6'h20,16'h1234,6'd0, 16'h0000,3'b000,16'h0000,16'h1234,1'b0,5'd0,1'b1}, // R12
    '{3'd2,1'b0,2'd0,16'h0000,6'h00,16'h0302,6'd0, 16'h0302,3'b100,16'h02A2,16'h0302,1'b0,5'd26,1'b0}, // R11 R8
    '{3'd2,1'b0,2'd1,16'h0000,6'h00,16'h001A,6'd0, 16'h001A,3'b001,16'h001A,16'h001A,1'b0,5'd28,1'b0}, // R11 R8
    '{3'd3,1'b0,2'd0,16'h0000,6'h00,16'h01FF,6'd0, 16'h01FF,3'b100,16'h019F,16'h0200,1'b1,5'd26,1'b0}, // R9
    '{3'd3,1'b0,2'd2,16'h0000,6'h00,16'hFFFF,6'd0, 16'hFFFF,3'b100,16'hFF9F,16'h0000,1'b1,5'd30,1'b0}, // R9 R8
    '{3'd3,1'b0,2'd1,16'h0000,6'h00,16'h0040,6'd0, 16'h0040,3'b010,16'h0020,16'h0041,1'b1,5'd28,1'b0}, // R9
    '{3'd4,1'b0,2'd2,16'h0000,6'h00,16'h0401,6'd4, 16'h0405,3'b100,16'h03A5,16'h0401,1'b0,5'd30,1'b0}, // R10
    '{3'd4,1'b0,2'd1,16'h0000,6'h00,16'hFFF0,6'd63,16'h002F,3'b010,16'h000F,16'hFFF0,1'b0,5'd28,1'b0}, // R10
    '{3'd4,1'b0,2'd0,16'h0000,6'h00,16'h0000,6'd0, 16'h0000,3'b001,16'h0000,16'h0000,1'b0,5'd26,1'b0}, // R10
    '{3'd2,1'b0,2'd3,16'h0000,6'h00,16'h1234,6'd0, 16'h0000,3'b000,16'h0000,16'h1234,1'b0,5'd0,1'b1}, // R12
    '{3'd3,1'b0,2'd3,16'h0000,6'h00,16'h00FF,6'd0, 16'h0000,3'b000,16'h0000,16'h00FF,1'b0,5'd0,1'b1}, // R12
    '{3'd5,1'b0,2'd0,16'h0040,6'h00,16'h1234,6'd0, 16'h0000,3'b000,16'h0000,16'h1234,1'b0,5'd0,1'b1}, // R12
    '{3'd0,1'b1,2'd0,16'h0045,6'h3F,16'h1234,6'd0, 16'h0045,3'b010,16'h0025,16'h1234,1'b0,5'd0,1'b0}  // R12 R6
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:         return "R3/R5";
      2, 3:         return "R6";
      4, 5, 6:      return "R7";
      7, 8, 9:      return "R4";
      12, 13:       return "R11/R8";
      14, 15, 16:   return "R9";
      17, 18, 19:   return "R10";
      default:      return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000ns;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && eff_addr == 0 && tgt_sel == 0 && local_idx == 0 && ptr_next == 0 &&
          !ptr_wb && ptr_reg_idx == 0 && !illegal, "R1",
          $sformatf("reset outputs actual valid=%b eff=%h tgt=%b expected all zero", out_valid, eff_addr, tgt_sel));
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && tgt_sel == 0, "R1",
          $sformatf("idle after reset actual valid=%b tgt=%b expected 0 000", out_valid, tgt_sel));

    for (int i = 0; i < N; i++) begin
      vec_t v = VECS[i];
      mode = v.m; bit_op = v.b; ptr_sel = v.s; imm_addr = v.imm;
      io_addr = v.io; ptr_val = v.p; disp = v.q; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(out_valid && eff_addr == v.e_addr && tgt_sel == v.e_tgt && local_idx == v.e_idx &&
            ptr_next == v.e_next && ptr_wb == v.e_wb && ptr_reg_idx == v.e_pidx && illegal == v.e_ill,
            tag_of(i),
            $sformatf("vec %0d actual v=%b a=%h t=%b i=%h n=%h w=%b p=%0d x=%b expected a=%h t=%b i=%h n=%h w=%b p=%0d x=%b",
                      i, out_valid, eff_addr, tgt_sel, local_idx, ptr_next, ptr_wb, ptr_reg_idx, illegal,
                      v.e_addr, v.e_tgt, v.e_idx, v.e_next, v.e_wb, v.e_pidx, v.e_ill));
    end

    // R2: post-increment result, then an idle cycle drops both strobes
    mode = 3'd3; ptr_sel = 2'd0; ptr_val = 16'h00FF; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(ptr_wb && ptr_next == 16'h0100, "R9",
          $sformatf("carry actual wb=%b next=%h expected 1 0100", ptr_wb, ptr_next));
    @(negedge clk);
    check(!out_valid && !ptr_wb, "R2",
          $sformatf("idle strobes actual valid=%b wb=%b expected 0 0", out_valid, ptr_wb));
    check(ptr_next == 16'h0100 && eff_addr == 16'h00FF, "R2",
          $sformatf("hold actual next=%h eff=%h expected 0100 00FF", ptr_next, eff_addr));

    // R2: back-to-back requests keep out_valid high, wb follows the mode each cycle
    mode = 3'd3; ptr_val = 16'h0010; req_valid = 1'b1;
    @(negedge clk);
    mode = 3'd2; ptr_val = 16'h0011;
    check(out_valid && ptr_wb, "R2", $sformatf("b2b first actual v=%b w=%b expected 1 1", out_valid, ptr_wb));
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid && !ptr_wb && eff_addr == 16'h0011, "R11",
          $sformatf("b2b second actual v=%b w=%b eff=%h expected 1 0 0011", out_valid, ptr_wb, eff_addr));

    // R1: reset in mid-run clears held results
    rst_n = 1'b0;
    @(negedge clk);
    check(!out_valid && eff_addr == 0 && ptr_next == 0 && tgt_sel == 0, "R1",
          $sformatf("mid reset actual eff=%h next=%h tgt=%b expected 0 0 000", eff_addr, ptr_next, tgt_sel));
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule